// File: doc/BRIEF.md
# Power Mode State Controller

This block is the system-mode sequencer of a supply and bus-interface companion die. It holds the chip in one of five modes (Off, Standby, Normal, Sleep, Overtemp) and from that mode it drives the enables of the two supply regulators, the enables of the two bus transceivers, an active-low limp-home output and a reset request towards the host processor. The analog detectors stay outside the block. Battery power-on, battery power-off and overtemperature all arrive as level flags.

A host register bank writes mode requests with a one-cycle strobe. The block latches wake-up events from enabled sources and checks that a sleep request is safe before it allows it. A rejected sleep request is never silently dropped. The controller goes back to Standby and issues a short reset, so the host always restarts in a known state. Every path back into Standby after a fault, wake-up or start-up passes through a timed reset. Start-up from Off uses a long pulse and all other resets use a short one.

Transitions: Off to Standby on power-on. Standby to Normal and Normal to Standby on request. Standby or Normal to Sleep on an accepted sleep request. Standby or Normal to Standby with a reset on a rejected one. Sleep to Standby on a wake-up. Standby, Normal or Sleep to Overtemp on overheat. Overtemp to Standby when the temperature recovers. Any mode goes to Off on battery loss.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: When bat_low_i is high, the next mode is Off (mode_o = 0) from every mode. This takes precedence over every other input. In Off, all four enables are low, limp_n_o is high, rst_req_o is high and wake_pend_o is cleared.
- R2: In Off, bat_ok_i high moves the controller to Standby (mode_o = 1). rst_req_o then stays high for exactly RST_LONG_CYC cycles after the transition.
- R3: When over_temp_i is high in Standby, Normal or Sleep, the next mode is Overtemp (mode_o = 4). In that mode both regulator enables and both transceiver enables are low, and limp_n_o is low. A low battery still wins over overtemperature.
- R4: In Overtemp, over_temp_i low moves the controller to Standby, with rst_req_o high for exactly RST_SHORT_CYC cycles.
- R5: Mode requests take effect only in Standby or Normal, on the cycle mode_wr_i is high. The mode_req_i codes are 2'b01 Standby, 2'b10 Sleep, 2'b11 Normal and 2'b00 no change. The outputs follow the mode: Standby has only vreg1_en_o high; Normal (mode_o = 2) has vreg1, vreg2, can_en_o and lin_en_o high; Sleep (mode_o = 3) has all four low.
- R6: A Sleep request is accepted only when all of the following hold:
  - irq_pend_i is low.
  - wake_pend_o is all zero.
  - No enabled wake event is arriving in the same cycle.
  - At least one bit of wake_en_i is set.
  The wake source bits are: bit 0 CAN, bit 1 LIN, bit 2 local wake pin.
- R7: A Sleep request that fails R6 moves the controller to Standby, with rst_req_o high for RST_SHORT_CYC cycles.
- R8: In Sleep, a wake event on an enabled source moves the controller to Standby, with a short reset. Events on disabled sources leave the mode unchanged.
- R9: Each bit of wake_pend_o sets on an enabled wake event. All bits clear on the cycle the controller enters Normal, and clearing wins over an event arriving in that same cycle.
- R10: Mode requests are ignored while rst_req_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; forces Off |
| bat_ok_i | input | 1 | Battery above power-on threshold |
| bat_low_i | input | 1 | Battery below power-off threshold |
| over_temp_i | input | 1 | Chip temperature above shutdown threshold |
| mode_wr_i | input | 1 | Mode request strobe |
| mode_req_i | input | 2 | Requested mode code |
| irq_pend_i | input | 1 | An interrupt is pending |
| wake_evt_i | input | WAKE_SRCS | Wake-up events, one per source |
| wake_en_i | input | WAKE_SRCS | Wake source enables |
| mode_o | output | 3 | Current mode code |
| vreg1_en_o | output | 1 | Host supply regulator enable |
| vreg2_en_o | output | 1 | Transceiver supply regulator enable |
| can_en_o | output | 1 | CAN transceiver enable |
| lin_en_o | output | 1 | LIN transceiver enable |
| limp_n_o | output | 1 | Limp-home output, active low |
| rst_req_o | output | 1 | Reset request to host |
| wake_pend_o | output | WAKE_SRCS | Latched pending wake-ups |

## Verification
Two events can land on the same cycle: the wake-pending latch being set by an enabled event, and the latch being cleared by entry into Normal. The bench provokes this by issuing the Normal request together with a LIN wake event. It then expects wake_pend_o to read zero after that edge and to rise again on a later event. A second collision places a wake event on the same cycle as a Sleep request, and the expected result is a rejected request with a short reset. Battery loss arriving while overtemperature is high checks the priority between the two forced transitions.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    typedef enum logic [2:0] {
        PM_OFF   = 3'd0,
        PM_STBY  = 3'd1,
        PM_NORM  = 3'd2,
        PM_SLEEP = 3'd3,
        PM_HOT   = 3'd4
    } pm_mode_e;

    localparam logic [1:0] REQ_KEEP  = 2'b00;
    localparam logic [1:0] REQ_STBY  = 2'b01;
    localparam logic [1:0] REQ_SLEEP = 2'b10;
    localparam logic [1:0] REQ_NORM  = 2'b11;
endpackage

// File: rtl/pmc_wake_latch.sv
module pmc_wake_latch #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] pend_o
);
    for (genvar g = 0; g < N; g++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                pend_o[g] <= 1'b0;
            else if (clr_i)
                pend_o[g] <= 1'b0;
            else if (set_i[g])
                pend_o[g] <= 1'b1;
        end
    end
endmodule

// File: rtl/pmc_sleep_gate.sv
module pmc_sleep_gate #(
    parameter int unsigned N = 3
) (
    input  logic         irq_i,
    input  logic [N-1:0] pend_i,
    input  logic [N-1:0] fresh_i,
    input  logic [N-1:0] en_i,
    output logic         ok_o
);
    // Sleep is safe only with nothing outstanding and a way to come back.
    always_comb begin
        ok_o = !irq_i && (pend_i == '0) && (fresh_i == '0) && (en_i != '0);
    end
endmodule

// File: rtl/pmc_rst_timer.sv
module pmc_rst_timer #(
    parameter int unsigned SHORT_CYC = 180000,
    parameter int unsigned LONG_CYC  = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ld_short_i,
    input  logic ld_long_i,
    output logic busy_o
);
    localparam int unsigned MAXC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
    localparam int unsigned CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (ld_long_i)
            cnt_q <= CW'(LONG_CYC);
        else if (ld_short_i)
            cnt_q <= CW'(SHORT_CYC);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o = (cnt_q != '0);

    // R7 / R4: a loaded short pulse is visible on the next cycle
    a_r7_short_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_short_i && !ld_long_i) |=> busy_o);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int unsigned WAKE_SRCS    = 3,
    parameter int unsigned RST_SHORT_CYC = 180000,
    parameter int unsigned RST_LONG_CYC  = 1000000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bat_ok_i,
    input  logic                 bat_low_i,
    input  logic                 over_temp_i,
    input  logic                 mode_wr_i,
    input  logic [1:0]           mode_req_i,
    input  logic                 irq_pend_i,
    input  logic [WAKE_SRCS-1:0] wake_evt_i,
    input  logic [WAKE_SRCS-1:0] wake_en_i,
    output logic [2:0]           mode_o,
    output logic                 vreg1_en_o,
    output logic                 vreg2_en_o,
    output logic                 can_en_o,
    output logic                 lin_en_o,
    output logic                 limp_n_o,
    output logic                 rst_req_o,
    output logic [WAKE_SRCS-1:0] wake_pend_o
);
    pm_mode_e             state_q, state_d;
    logic                 ld_short, ld_long, clr_pend;
    logic                 tmr_busy, sleep_ok, req_live;
    logic [WAKE_SRCS-1:0] fresh_wake;

    assign fresh_wake = wake_evt_i & wake_en_i;
    assign req_live   = mode_wr_i && !rst_req_o;

    pmc_sleep_gate #(.N(WAKE_SRCS)) u_gate (
        .irq_i   (irq_pend_i),
        .pend_i  (wake_pend_o),
        .fresh_i (fresh_wake),
        .en_i    (wake_en_i),
        .ok_o    (sleep_ok)
    );

    pmc_rst_timer #(.SHORT_CYC(RST_SHORT_CYC), .LONG_CYC(RST_LONG_CYC)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_short_i (ld_short),
        .ld_long_i  (ld_long),
        .busy_o     (tmr_busy)
    );

    pmc_wake_latch #(.N(WAKE_SRCS)) u_wake (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (fresh_wake),
        .clr_i  (clr_pend),
        .pend_o (wake_pend_o)
    );

    // Next-state selection
    always_comb begin
        state_d  = state_q;
        ld_short = 1'b0;
        ld_long  = 1'b0;
        if (bat_low_i) begin
            state_d = PM_OFF;
        end else begin
            unique case (state_q)
                PM_OFF: begin
                    if (bat_ok_i) begin
                        state_d = PM_STBY;
                        ld_long = 1'b1;
                    end
                end
                PM_HOT: begin
                    if (!over_temp_i) begin
                        state_d  = PM_STBY;
                        ld_short = 1'b1;
                    end
                end
                PM_SLEEP: begin
                    if (over_temp_i) begin
                        state_d = PM_HOT;
                    end else if (fresh_wake != '0) begin
                        state_d  = PM_STBY;
                        ld_short = 1'b1;
                    end
                end
                PM_STBY, PM_NORM: begin
                    if (over_temp_i) begin
                        state_d = PM_HOT;
                    end else if (req_live) begin
                        unique case (mode_req_i)
                            REQ_SLEEP: begin
                                if (sleep_ok) begin
                                    state_d = PM_SLEEP;
                                end else begin
                                    state_d  = PM_STBY;
                                    ld_short = 1'b1;
                                end
                            end
                            REQ_NORM: state_d = PM_NORM;
                            REQ_STBY: state_d = PM_STBY;
                            default:  state_d = state_q;
                        endcase
                    end
                end
                default: state_d = PM_OFF;
            endcase
        end
    end

    assign clr_pend = (state_d == PM_OFF) || (state_q == PM_OFF) ||
                      ((state_d == PM_NORM) && (state_q != PM_NORM));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= PM_OFF;
        else
            state_q <= state_d;
    end

    // Output decode
    always_comb begin
        vreg1_en_o = 1'b0;
        vreg2_en_o = 1'b0;
        can_en_o   = 1'b0;
        lin_en_o   = 1'b0;
        limp_n_o   = 1'b1;
        unique case (state_q)
            PM_OFF:   ;
            PM_STBY:  vreg1_en_o = 1'b1;
            PM_NORM: begin
                vreg1_en_o = 1'b1;
                vreg2_en_o = 1'b1;
                can_en_o   = 1'b1;
                lin_en_o   = 1'b1;
            end
            PM_SLEEP: ;
            PM_HOT:   limp_n_o = 1'b0;
            default:  ;
        endcase
    end

    assign mode_o    = state_q;
    assign rst_req_o = (state_q == PM_OFF) || tmr_busy;

    // R1: battery loss forces Off from any mode
    a_r1_bat_off: assert property (@(posedge clk) disable iff (!rst_n)
        bat_low_i |=> (mode_o == PM_OFF));

    // R3: overheat from an active mode forces Overtemp
    a_r3_hot_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (over_temp_i && !bat_low_i && (state_q inside {PM_STBY, PM_NORM, PM_SLEEP}))
        |=> (mode_o == PM_HOT) && !limp_n_o);

    // R6: Sleep is only ever entered with the entry conditions met
    a_r6_sleep_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PM_SLEEP && state_d == PM_SLEEP)
        |-> (!irq_pend_i && wake_pend_o == '0 && wake_en_i != '0));

    // R8: an enabled wake in Sleep returns to Standby under reset
    a_r8_wake_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_SLEEP && fresh_wake != '0 && !bat_low_i && !over_temp_i)
        |=> (mode_o == PM_STBY) && rst_req_o);

    // R9: pending wake-ups read clear right after entering Normal
    a_r9_norm_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PM_NORM && state_d == PM_NORM) |=> (wake_pend_o == '0));

    // R10: Normal is never entered while the reset request is active
    a_r10_req_block: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req_o && state_q != PM_NORM) |=> (mode_o != PM_NORM));
endmodule

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;
    localparam int SHORT = 4;
    localparam int LONG  = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bat_ok = 0, bat_low = 0, hot = 0, wr = 0, irq = 0;
    logic [1:0] req = 2'b00;
    logic [2:0] evt = 3'b000, en = 3'b000;
    logic [2:0] mode;
    logic       v1, v2, can, lin, limp_n, rreq;
    logic [2:0] pend;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [12:0] exp_q[$];
    string       tag_q[$];

    int         m_mode = 0;
    int         m_cnt  = 0;
    logic [2:0] m_pend = 3'b000;

    always #10 clk = ~clk;

    pwr_mode_ctrl #(.WAKE_SRCS(3), .RST_SHORT_CYC(SHORT), .RST_LONG_CYC(LONG)) uut (
        .clk(clk), .rst_n(rst_n), .bat_ok_i(bat_ok), .bat_low_i(bat_low),
        .over_temp_i(hot), .mode_wr_i(wr), .mode_req_i(req), .irq_pend_i(irq),
        .wake_evt_i(evt), .wake_en_i(en), .mode_o(mode), .vreg1_en_o(v1),
        .vreg2_en_o(v2), .can_en_o(can), .lin_en_o(lin), .limp_n_o(limp_n),
        .rst_req_o(rreq), .wake_pend_o(pend)
    );

    // Driver: applies one cycle of stimulus and queues the predicted result
    task automatic step(input logic a_ok, input logic a_low, input logic a_hot,
                        input logic a_wr, input logic [1:0] a_req, input logic a_irq,
                        input logic [2:0] a_evt, input logic [2:0] a_en, input string tag);
        int         nm;
        bit         ls, ll, busy, ok;
        logic [2:0] q;
        logic [3:0] ens;
        logic       lp;
        @(negedge clk);
        bat_ok = a_ok; bat_low = a_low; hot = a_hot; wr = a_wr; req = a_req;
        irq = a_irq; evt = a_evt; en = a_en;
        nm = m_mode; ls = 0; ll = 0;
        q = a_evt & a_en;
        busy = (m_mode == 0) || (m_cnt != 0);
        ok = !a_irq && (m_pend == 3'b000) && (q == 3'b000) && (a_en != 3'b000);
        if (a_low) nm = 0;
        else if (m_mode == 0) begin if (a_ok) begin nm = 1; ll = 1; end end
        else if (m_mode == 4) begin if (!a_hot) begin nm = 1; ls = 1; end end
        else if (a_hot) nm = 4;
        else if (m_mode == 3) begin if (q != 0) begin nm = 1; ls = 1; end end
        else if (a_wr && !busy) begin
            if (a_req == 2'b10) begin
                if (ok) nm = 3; else begin nm = 1; ls = 1; end
            end else if (a_req == 2'b11) nm = 2;
            else if (a_req == 2'b01) nm = 1;
        end
        if (ll) m_cnt = LONG; else if (ls) m_cnt = SHORT; else if (m_cnt != 0) m_cnt--;
        if (nm == 0 || m_mode == 0 || (nm == 2 && m_mode != 2)) m_pend = 3'b000;
        else m_pend = m_pend | q;
        m_mode = nm;
        case (nm)
            1: ens = 4'b1000;
            2: ens = 4'b1111;
            default: ens = 4'b0000;
        endcase
        lp = (nm == 4) ? 1'b0 : 1'b1;
        exp_q.push_back({3'(nm), ens, lp, ((nm == 0) || (m_cnt != 0)), m_pend});
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n, input logic [2:0] a_en, input string tag);
        for (int i = 0; i < n; i++) step(1, 0, 0, 0, 2'b00, 0, 3'b000, a_en, tag);
    endtask

    // Monitor: compares each produced result against the queued prediction
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            logic [12:0] e, a;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = {mode, v1, v2, can, lin, limp_n, rreq, pend};
            n_vec++;
            if (a !== e) begin
                n_bad++;
                $display("FAIL %s: got %h expected %h", t, a, e);
            end
        end
    end

    initial begin
        #(20 * 4000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        step(0, 0, 0, 0, 2'b00, 0, 3'b000, 3'b000, "R1 reset state Off");
        step(0, 0, 1, 0, 2'b00, 0, 3'b000, 3'b000, "R3 overheat ignored in Off");
        step(1, 0, 0, 0, 2'b00, 0, 3'b000, 3'b011, "R2 power-on to Standby");
        step(1, 0, 0, 1, 2'b11, 0, 3'b000, 3'b011, "R10 request during long reset");
        idle(LONG, 3'b011, "R2 long reset width");
        step(1, 0, 0, 1, 2'b11, 0, 3'b000, 3'b011, "R5 Standby to Normal");
        step(1, 0, 0, 0, 2'b00, 0, 3'b010, 3'b011, "R9 LIN wake latched");
        step(1, 0, 0, 0, 2'b00, 0, 3'b100, 3'b011, "R9 disabled source not latched");
        step(1, 0, 0, 1, 2'b10, 0, 3'b000, 3'b011, "R7 sleep refused, wake pending");
        idle(SHORT, 3'b011, "R7 short reset width");
        step(1, 0, 0, 1, 2'b11, 0, 3'b010, 3'b011, "R9 Normal entry clears over new event");
        step(1, 0, 0, 0, 2'b00, 0, 3'b001, 3'b011, "R9 CAN wake latched in Normal");
        step(1, 0, 0, 1, 2'b01, 0, 3'b000, 3'b011, "R5 Normal to Standby");
        step(1, 0, 0, 1, 2'b11, 0, 3'b000, 3'b011, "R9 re-entry to Normal clears");
        step(1, 0, 0, 1, 2'b00, 0, 3'b000, 3'b011, "R5 keep code no change");
        step(1, 0, 0, 1, 2'b10, 1, 3'b000, 3'b011, "R6 sleep refused, interrupt");
        idle(SHORT, 3'b011, "R7 short reset width");
        step(1, 0, 0, 1, 2'b10, 0, 3'b000, 3'b000, "R6 sleep refused, no source");
        idle(SHORT, 3'b000, "R7 short reset width");
        step(1, 0, 0, 1, 2'b10, 0, 3'b001, 3'b011, "R6 sleep refused, same-cycle wake");
        idle(SHORT, 3'b011, "R7 short reset width");
        step(1, 0, 0, 1, 2'b11, 0, 3'b000, 3'b011, "R5 to Normal");
        step(1, 0, 0, 1, 2'b10, 0, 3'b000, 3'b011, "R6 sleep accepted");
        step(1, 0, 0, 1, 2'b11, 0, 3'b100, 3'b011, "R5 request ignored in Sleep");
        step(1, 0, 0, 0, 2'b00, 0, 3'b010, 3'b011, "R8 LIN wake exits Sleep");
        idle(SHORT, 3'b011, "R8 short reset width");
        step(1, 0, 0, 1, 2'b11, 0, 3'b000, 3'b011, "R5 to Normal");
        step(1, 0, 1, 0, 2'b00, 0, 3'b000, 3'b011, "R3 Normal to Overtemp");
        step(1, 0, 1, 1, 2'b11, 0, 3'b000, 3'b011, "R5 request ignored in Overtemp");
        step(1, 0, 0, 0, 2'b00, 0, 3'b000, 3'b011, "R4 recover to Standby");
        idle(SHORT, 3'b011, "R4 short reset width");
        step(1, 0, 0, 1, 2'b10, 0, 3'b000, 3'b100, "R6 sleep accepted");
        step(1, 0, 1, 0, 2'b00, 0, 3'b000, 3'b100, "R3 Sleep to Overtemp");
        step(0, 1, 1, 0, 2'b00, 0, 3'b000, 3'b100, "R1 battery loss beats overheat");
        step(0, 0, 0, 0, 2'b00, 0, 3'b100, 3'b100, "R1 held in Off");
        step(1, 0, 0, 0, 2'b00, 0, 3'b000, 3'b011, "R2 power-on again");
        idle(LONG, 3'b011, "R2 long reset width");
        step(1, 0, 0, 1, 2'b11, 0, 3'b000, 3'b011, "R5 to Normal");
        step(0, 1, 0, 0, 2'b00, 0, 3'b000, 3'b011, "R1 Normal to Off");
        step(0, 0, 0, 0, 2'b00, 0, 3'b000, 3'b011, "R1 stays Off");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule